// File: doc/BRIEF.md
# UART Receiver with Error-Tagged FIFO

This block is the receive half of an asynchronous serial port. It synchronises the serial line and samples it once per pulse of a 16x oversampling enable. A falling edge on the line is accepted as a start bit only if the line is still low at mid-bit. After that the block shifts in the data bits LSB first, takes an optional parity bit, and checks the stop bit.

Each finished character becomes one 12-bit entry. The entry holds the data byte and four condition flags: framing, parity, break and overrun. Entries go into a first-in first-out store. A bus reads the store one entry at a time: it sees the oldest entry and pops it with a single-cycle read strobe. When the store is switched to single-entry mode, it acts as a one-byte holding register.

A receive-timeout output goes high when data has stayed unread for a fixed number of oversampling ticks with no store activity. The baud divider that produces the tick lies outside the block, and so does any interrupt masking.

Top module: `uart_rx_tagged`

## Requirements
- R1: After reset, `empty` is 1, `full` is 0, `timeout` is 0 and `rd_data` is 0.
- R2: A low pulse on `rxd` that ends before the mid-point of a bit time is not taken as a start bit and stores nothing.
- R3: Data bits are sampled at mid-bit, LSB first, into `rd_data[7:0]`. The entry is stored once the stop bit has been sampled.
- R4: With `par_en` = 1, a parity bit follows the data. The total count of ones in data plus parity must be even when `par_odd` = 0 and odd when `par_odd` = 1. A mismatch sets `rd_data[9]`.
- R5: A stop bit sampled low sets `rd_data[8]`, the framing flag.
- R6: If every sample point of a frame reads low (start, data, parity if present, and stop), `rd_data[10]` (break) is set together with `rd_data[8]`. After that, no new start bit is accepted until the line has returned high.
- R7: With `fifo_en` = 1, up to DEPTH (16) entries are held and read in arrival order, and `full` is 1 exactly when DEPTH entries are held.
- R8: A character that completes while the store is full is discarded, and `rd_data[11]` (overrun) is set on the most recently stored entry.
- R9: With `fifo_en` = 0, the store holds one entry: `full` goes high after one character, and a second unread character causes an overrun on the held entry.
- R10: `timeout` rises TMO_TICKS (511) ticks after the last push or read while the store is non-empty. It falls on a read or a push, and it stays low while the store is empty.
- R11: `rd_data` shows the oldest entry, or 0 when the store is empty. `rd_en` on an empty store has no effect.
- R12: All bit timing follows `tick` and not `clk`: with one tick every two clocks, frames of 32 clocks per bit are received correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | 16x oversampling enable, one clock wide |
| rxd | input | 1 | Serial input, idle high |
| fifo_en | input | 1 | 1: DEPTH-entry store, 0: single holding register |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1: odd parity, 0: even parity |
| rd_en | input | 1 | Pop the oldest entry |
| rd_data | output | 12 | {overrun, break, parity err, framing err, data[7:0]} |
| empty | output | 1 | No entry held |
| full | output | 1 | Store at capacity for the current mode |
| timeout | output | 1 | Unread data aged TMO_TICKS ticks |

## Verification
The bench builds the block with its defaults: 16 ticks per bit, a 16-entry store, a 511-tick timeout and a two-flop input synchroniser. With these values, 17 frames are enough to fill the store and force an overrun, and the timeout edge falls within a few hundred clocks, so the bench can bracket it tightly on either side. The tick rate is a run-time stimulus rather than a parameter, so the same build also covers a halved tick rate. Changing the mode input covers the single-register variant.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
   localparam int ENTRY_W = 12;

   typedef struct packed {
      logic       ovr;
      logic       brk;
      logic       perr;
      logic       ferr;
      logic [7:0] data;
   } rx_entry_t;

   typedef enum logic [2:0] {
      RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP, RX_HOLD
   } rx_state_t;
endpackage

// File: rtl/uart_rx_deser.sv
module uart_rx_deser
   import uart_rx_pkg::*;
#(
   parameter int OVS         = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      tick,
   input  logic      rxd,
   input  logic      par_en,
   input  logic      par_odd,
   output logic      done,
   output rx_entry_t ent
);
   localparam int CW = $clog2(OVS);
   localparam logic [CW-1:0] MID  = CW'(OVS / 2 - 1);
   localparam logic [CW-1:0] LAST = CW'(OVS - 1);

   logic            rx_s;
   rx_state_t       st;
   logic [CW-1:0]   cnt;
   logic [2:0]      bidx;
   logic [7:0]      shreg;
   logic            all_low;
   logic            par_bad;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign rx_s = rxd;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sr;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sr <= '1;
            else        sr <= (sr << 1) | SYNC_STAGES'(rxd);
         end
         assign rx_s = sr[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= RX_IDLE;
         cnt     <= '0;
         bidx    <= '0;
         shreg   <= '0;
         all_low <= 1'b0;
         par_bad <= 1'b0;
         done    <= 1'b0;
         ent     <= '0;
      end else begin
         done <= 1'b0;
         if (tick) begin
            unique case (st)
               RX_IDLE: if (!rx_s) begin
                  st  <= RX_START;
                  cnt <= '0;
               end
               RX_START: if (cnt == MID) begin
                  cnt <= '0;
                  if (!rx_s) begin
                     st      <= RX_DATA;
                     bidx    <= '0;
                     all_low <= 1'b1;
                     par_bad <= 1'b0;
                  end else begin
                     st <= RX_IDLE;
                  end
               end else cnt <= cnt + CW'(1);
               RX_DATA: if (cnt == LAST) begin
                  cnt     <= '0;
                  shreg   <= {rx_s, shreg[7:1]};
                  all_low <= all_low & ~rx_s;
                  if (bidx == 3'd7) st <= par_en ? RX_PAR : RX_STOP;
                  else              bidx <= bidx + 3'd1;
               end else cnt <= cnt + CW'(1);
               RX_PAR: if (cnt == LAST) begin
                  cnt     <= '0;
                  par_bad <= rx_s ^ (^shreg) ^ par_odd;
                  all_low <= all_low & ~rx_s;
                  st      <= RX_STOP;
               end else cnt <= cnt + CW'(1);
               RX_STOP: if (cnt == LAST) begin
                  cnt       <= '0;
                  done      <= 1'b1;
                  ent.ovr   <= 1'b0;
                  ent.brk   <= all_low & ~rx_s;
                  ent.perr  <= par_bad;
                  ent.ferr  <= ~rx_s;
                  ent.data  <= shreg;
                  st        <= rx_s ? RX_IDLE : RX_HOLD;
               end else cnt <= cnt + CW'(1);
               RX_HOLD: if (rx_s) st <= RX_IDLE;
               default: st <= RX_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/uart_rx_store.sv
module uart_rx_store
   import uart_rx_pkg::*;
#(
   parameter int DEPTH = 16
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      fifo_en,
   input  logic      push,
   input  rx_entry_t wdata,
   input  logic      pop_req,
   output rx_entry_t head,
   output logic      empty,
   output logic      full,
   output logic      activity
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);
   localparam bit POW2 = (DEPTH & (DEPTH - 1)) == 0;

   rx_entry_t     mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt, last_idx;
   logic [CW-1:0] count, cap;
   logic          wr_acc, pop, ovr_mark;

   assign cap      = fifo_en ? CW'(DEPTH) : CW'(1);
   assign empty    = (count == '0);
   assign full     = (count >= cap);
   assign pop      = pop_req & ~empty;
   assign wr_acc   = push & ~full;
   assign ovr_mark = push & full;
   assign activity = wr_acc | pop;
   assign head     = empty ? '0 : mem[rd_ptr];

   generate
      if (POW2) begin : g_pow2
         assign wr_nxt   = wr_ptr + AW'(1);
         assign rd_nxt   = rd_ptr + AW'(1);
         assign last_idx = wr_ptr - AW'(1);
      end else begin : g_wrap
         assign wr_nxt   = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);
         assign rd_nxt   = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);
         assign last_idx = (wr_ptr == '0) ? AW'(DEPTH - 1) : wr_ptr - AW'(1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (wr_acc)        mem[wr_ptr]       <= wdata;
      else if (ovr_mark) mem[last_idx].ovr <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (wr_acc) wr_ptr <= wr_nxt;
         if (pop)    rd_ptr <= rd_nxt;
         unique case ({wr_acc, pop})
            2'b10:   count <= count + CW'(1);
            2'b01:   count <= count - CW'(1);
            default: count <= count;
         endcase
      end
   end
endmodule

// File: rtl/uart_rx_tmo.sv
module uart_rx_tmo #(
   parameter int LIMIT = 511
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic empty,
   input  logic restart,
   output logic timeout
);
   localparam int TW = $clog2(LIMIT + 1);
   localparam logic [TW-1:0] LIM = TW'(LIMIT);

   logic [TW-1:0] age;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    age <= '0;
      else if (empty || restart)     age <= '0;
      else if (tick && age != LIM)   age <= age + TW'(1);
   end

   assign timeout = (age == LIM);
endmodule

// File: rtl/uart_rx_tagged.sv
module uart_rx_tagged
   import uart_rx_pkg::*;
#(
   parameter int OVS         = 16,
   parameter int DEPTH       = 16,
   parameter int TMO_TICKS   = 511,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tick,
   input  logic                rxd,
   input  logic                fifo_en,
   input  logic                par_en,
   input  logic                par_odd,
   input  logic                rd_en,
   output logic [ENTRY_W-1:0]  rd_data,
   output logic                empty,
   output logic                full,
   output logic                timeout
);
   initial begin
      assert (OVS >= 4 && OVS % 2 == 0) else $error("OVS must be even and at least 4");
      assert (DEPTH >= 2)               else $error("DEPTH must be at least 2");
      assert (TMO_TICKS >= 1)           else $error("TMO_TICKS must be at least 1");
      assert (SYNC_STAGES >= 0)         else $error("SYNC_STAGES must not be negative");
   end

   rx_entry_t rx_ent, head;
   logic      rx_done, activity;

   uart_rx_deser #(.OVS(OVS), .SYNC_STAGES(SYNC_STAGES)) u_deser (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .rxd     (rxd),
      .par_en  (par_en),
      .par_odd (par_odd),
      .done    (rx_done),
      .ent     (rx_ent)
   );

   uart_rx_store #(.DEPTH(DEPTH)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .fifo_en  (fifo_en),
      .push     (rx_done),
      .wdata    (rx_ent),
      .pop_req  (rd_en),
      .head     (head),
      .empty    (empty),
      .full     (full),
      .activity (activity)
   );

   uart_rx_tmo #(.LIMIT(TMO_TICKS)) u_tmo (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .empty   (empty),
      .restart (activity),
      .timeout (timeout)
   );

   assign rd_data = head;
endmodule

// File: rtl/uart_rx_tagged_chk.sv
module uart_rx_tagged_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        rd_en,
   input logic        empty,
   input logic        full,
   input logic        timeout,
   input logic        rx_done,
   input logic [11:0] rd_data
);
   // R7
   empty_full_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(empty && full));

   // R10
   tmo_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      timeout |-> !empty);

   // R10
   tmo_read_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(timeout) |-> !$past(rd_en));

   // R8
   ovr_keeps_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (full && rx_done && !rd_en) |=> full);

   // R11
   head_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!empty && !rd_en && !rx_done) |=> $stable(rd_data));

   // R11
   empty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && !rx_done) |=> empty);
endmodule

bind uart_rx_tagged uart_rx_tagged_chk u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .rd_en   (rd_en),
   .empty   (empty),
   .full    (full),
   .timeout (timeout),
   .rx_done (rx_done),
   .rd_data (rd_data)
);

// File: tb/uart_rx_tagged_tb.sv
module uart_rx_tagged_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic        rxd = 1'b1;
   logic        fifo_en = 1'b1;
   logic        par_en = 1'b0;
   logic        par_odd = 1'b0;
   logic        rd_en = 1'b0;
   logic [11:0] rd_data;
   logic        empty, full, timeout;

   int checks = 0;
   int fails  = 0;
   int tick_div = 1;
   int tick_cnt = 0;
   bit done_flag = 0;

   always #4 clk = ~clk;

   uart_rx_tagged u_dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd), .fifo_en(fifo_en),
      .par_en(par_en), .par_odd(par_odd), .rd_en(rd_en), .rd_data(rd_data),
      .empty(empty), .full(full), .timeout(timeout)
   );

   initial forever begin
      @(negedge clk);
      tick_cnt++;
      if (tick_cnt >= tick_div) begin tick = 1'b1; tick_cnt = 0; end
      else tick = 1'b0;
   end

   // {data[7:0], par_en, par_odd, flip_parity, low_stop, expected[11:0]}
   localparam logic [23:0] VECS [0:7] = '{
      {8'h55, 4'b0000, 12'h055},   // R3 plain byte
      {8'hA3, 4'b1000, 12'h0A3},   // R4 even parity good
      {8'h3C, 4'b1100, 12'h03C},   // R4 odd parity good
      {8'h81, 4'b1010, 12'h281},   // R4 even parity bad
      {8'h7E, 4'b0001, 12'h17E},   // R5 framing
      {8'h00, 4'b0001, 12'h500},   // R6 break, no parity
      {8'h00, 4'b1001, 12'h500},   // R6 break with parity
      {8'hFF, 4'b1111, 12'h3FF}    // R4 R5 bad parity and stop
   };

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic send(input logic [7:0] d, input logic pen, input logic podd,
                       input logic flip, input logic low_stop);
      int bt;
      bt = 16 * tick_div;
      par_en  = pen;
      par_odd = podd;
      rxd = 1'b0; cyc(bt);
      for (int i = 0; i < 8; i++) begin rxd = d[i]; cyc(bt); end
      if (pen) begin rxd = (^d) ^ podd ^ flip; cyc(bt); end
      rxd = ~low_stop; cyc(bt);
      rxd = 1'b1; cyc(bt);
   endtask

   task automatic pop_one();
      rd_en = 1'b1; cyc(1); rd_en = 1'b0;
   endtask

   task automatic finish_run();
      if (!done_flag) begin
         done_flag = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      cyc(3);
      check("R1 empty", empty, 1);
      check("R1 full", full, 0);
      check("R1 timeout", timeout, 0);
      check("R1 rd_data", rd_data, 0);
      rst_n = 1'b1;
      cyc(3);

      for (int v = 0; v < 8; v++) begin
         send(VECS[v][23:16], VECS[v][15], VECS[v][14], VECS[v][13], VECS[v][12]);
         check($sformatf("R3 vec%0d stored", v), empty, 0);
         check($sformatf("R3 vec%0d entry", v), rd_data, VECS[v][11:0]);
         pop_one();
         check($sformatf("R11 vec%0d drained", v), empty, 1);
      end

      // R2: short glitch is not a start bit
      rxd = 1'b0; cyc(4); rxd = 1'b1; cyc(200);
      check("R2 glitch ignored", empty, 1);
      send(8'h96, 0, 0, 0, 0);
      check("R2 next frame ok", rd_data, 12'h096);
      pop_one();

      // R11: read on empty has no effect
      pop_one();
      check("R11 empty read", empty, 1);
      check("R11 zero when empty", rd_data, 0);
      send(8'h11, 0, 0, 0, 0);
      check("R11 head after empty read", rd_data, 12'h011);
      pop_one();

      // R7/R8: fill, overflow, drain in order
      for (int k = 0; k < 16; k++) send(8'h10 + 8'(k), 0, 0, 0, 0);
      check("R7 full at depth", full, 1);
      send(8'hEE, 0, 0, 0, 0);
      check("R8 still full", full, 1);
      for (int k = 0; k < 16; k++) begin
         check($sformatf("R7 R8 order %0d", k), rd_data,
               {(k == 15), 3'b000, 8'h10 + 8'(k)});
         if (k == 0) check("R7 not full after first read pending", full, 1);
         pop_one();
      end
      check("R7 drained", empty, 1);

      // R9: single holding register
      fifo_en = 1'b0;
      send(8'h42, 0, 0, 0, 0);
      check("R9 full after one", full, 1);
      send(8'h43, 0, 0, 0, 0);
      check("R9 overrun on held", rd_data, 12'h842);
      pop_one();
      check("R9 empty after read", empty, 1);
      fifo_en = 1'b1;

      // R10: timeout
      fork send(8'h5A, 0, 0, 0, 0); join_none
      while (empty) cyc(1);
      cyc(505);
      check("R10 not yet", timeout, 0);
      cyc(10);
      check("R10 fired", timeout, 1);
      pop_one();
      check("R10 cleared by read", timeout, 0);
      cyc(600);
      check("R10 low while empty", timeout, 0);

      // R12: slower tick
      tick_div = 2;
      send(8'hC5, 0, 0, 0, 0);
      check("R12 slow tick entry", rd_data, 12'h0C5);
      pop_one();
      tick_div = 1;

      finish_run();
   end
endmodule